// File: doc/BRIEF.md
# Collision Retry Controller with Replay Buffer

This block sits between a frame fetcher and a half-duplex transmitter. It sees one frame through from its first attempt to its final outcome. The fetcher writes the frame bytes into a small replay buffer, and the transmitter reads bytes out of that buffer as it sends them. The transmitter pulses `byte_tick` once per byte time, both while it sends and while it is silent. The bytes at the head of the frame stay protected in the buffer until the collision window has passed. An early collision therefore rewinds the read side to the first byte of the frame, and nothing has to be fetched again.

After an early collision the controller waits a random backoff. The backoff is a whole number of slot times (one slot is `SLOT_BYTES` byte ticks), and the number of slots is drawn from a free-running LFSR. The range of the draw doubles with each collision until it reaches a cap. When the backoff ends, the controller pulses `restart` so that the transmitter begins the frame again. If the final permitted attempt also collides, the controller marks a retry failure. A collision that arrives after the window is a late collision: it is never retried and is reported with its own flag. In every outcome the controller pulses `frame_release` so that the queue can move on to the next frame.

Top module: `coll_retry_ctrl`

## Requirements
- R1: On reset, `attempts` is 0. On `frame_start`, from any state, the buffer is emptied and `attempts` becomes 1. On either one, `done`, `retry_err`, `late_err` and `buf_release` all read 0, and any write presented in the same cycle as `frame_start` is discarded.
- R2: During an attempt, `buf_release` rises one cycle after the `SLOT_BYTES`-th `byte_tick` of that attempt if no collision has come first. An early collision rewinds the read side, so the first byte of the frame is shown on `rd_data` again.
- R3: `attempts` counts the attempts made on the current frame (the first attempt plus the retries) and never exceeds `MAX_ATTEMPTS`.
- R4: A collision during attempt number `MAX_ATTEMPTS` sets `retry_err`, pulses `frame_release` for one cycle and returns the block to idle, where it starts no further attempt.
- R5: After the n-th collision, `backoff_slots` holds a value between 0 and 2^min(n, `BACKOFF_CAP`) − 1. The backoff then lasts `backoff_slots` × `SLOT_BYTES` byte ticks, and `restart` pulses for one cycle when it expires.
- R6: A collision after `buf_release` has risen sets `late_err`, pulses `frame_release` and is not retried.
- R7: A `tx_end` during an attempt with no collision in the same cycle sets `done`, leaves both error flags clear and pulses `frame_release`. A collision in that same cycle takes priority over `tx_end`.
- R8: While `buf_release` is low, `wr_full` is raised once `BUF_DEPTH` bytes have been written since `frame_start`, however many bytes have been read. After release, bytes that have been read free their space.
- R9: `collision`, `tx_end` and `rd_en` have no effect while the block is idle or backing off. They change neither the flags nor `attempts`, nor the buffer's read position.
- R10: `rd_data` shows the oldest unread byte of the frame, in write order, and `rd_empty` is high when every written byte has been read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | Begins a new frame and clears all per-frame state |
| wr_en | input | 1 | Writes `wr_data` into the replay buffer |
| wr_data | input | DATA_W | Frame byte from the fetcher |
| rd_en | input | 1 | Transmitter takes the byte on `rd_data` |
| byte_tick | input | 1 | One pulse per byte time on the medium |
| tx_end | input | 1 | Transmitter finished the frame |
| collision | input | 1 | Collision seen during transmission |
| rd_data | output | DATA_W | Oldest unread byte |
| rd_empty | output | 1 | No unread byte in the buffer |
| wr_full | output | 1 | Buffer cannot accept a byte |
| restart | output | 1 | One-cycle pulse: begin the next attempt |
| buf_release | output | 1 | Collision window passed; protected bytes may be reused |
| frame_release | output | 1 | One-cycle pulse: frame finished, move to the next one |
| done | output | 1 | Frame sent successfully |
| retry_err | output | 1 | All attempts ended in collisions |
| late_err | output | 1 | Collision after the window |
| attempts | output | $clog2(MAX_ATTEMPTS+1) | Attempts made on the current frame |
| backoff_slots | output | BACKOFF_CAP | Slot count drawn for the latest backoff |

## Verification
The controller is tried with the following patterns:
- A clean frame. This separates the release point from the completion path.
- A frame with a single early collision. This shows that the rewind really replays the first byte and that the backoff length follows the drawn slot count.
- A frame that collides on every attempt. This walks the attempt counter up to its limit and shows the exact attempt on which the block gives up.
- A collision just past the window. This tells a late collision apart from a retryable one.
- A fill without reads. This shows that protected bytes hold the buffer full until release.
- Stray controls while idle, and a new frame arriving during a backoff. These check that idle inputs are ignored and that a new frame clears all per-frame state.

// File: rtl/rc_pkg.sv
package rc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEND = 2'd1,
        ST_WAIT = 2'd2
    } rc_state_e;

    typedef struct packed {
        logic done;
        logic retry_err;
        logic late_err;
    } rc_status_t;

    // Exponent of the backoff range: the collision count, capped.
    function automatic int unsigned rc_cap_exp(input int unsigned n, input int unsigned cap);
        return (n < cap) ? n : cap;
    endfunction

endpackage

// File: rtl/rc_lfsr.sv
module rc_lfsr #(
    parameter logic [15:0] SEED = 16'hACE1
) (
    input  logic        clk,
    input  logic        rst,
    output logic [15:0] value
);
    logic [15:0] q;
    logic        fb;

    // x^16 + x^14 + x^13 + x^11 + 1
    assign fb = q[15] ^ q[13] ^ q[12] ^ q[10];

    always_ff @(posedge clk) begin
        if (rst) q <= (SEED == 16'h0) ? 16'h1 : SEED;
        else     q <= {q[14:0], fb};
    end

    assign value = q;
endmodule

// File: rtl/rc_replay_buf.sv
module rc_replay_buf #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned DEPTH  = 128
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic              rewind,
    input  logic              release_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              empty,
    output logic              full
);
    localparam int unsigned AW = $clog2(DEPTH);
    localparam int unsigned PW = AW + 1;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PW-1:0]     wr_p, rd_p, base_p, rd_nxt, used;
    logic              wr_fire;

    assign used    = wr_p - base_p;
    assign full    = (used == PW'(DEPTH));
    assign empty   = (rd_p == wr_p);
    assign wr_fire = wr_en && !full && !flush;

    always_comb begin
        if (rewind)              rd_nxt = base_p;
        else if (rd_en && !empty) rd_nxt = rd_p + PW'(1);
        else                     rd_nxt = rd_p;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_p   <= '0;
            rd_p   <= '0;
            base_p <= '0;
        end else begin
            if (wr_fire) wr_p <= wr_p + PW'(1);
            rd_p <= rd_nxt;
            if (release_en) base_p <= rd_nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_fire) mem[wr_p[AW-1:0]] <= wr_data;
    end

    assign rd_data = mem[rd_p[AW-1:0]];
endmodule

// File: rtl/coll_retry_ctrl.sv
module coll_retry_ctrl
    import rc_pkg::*;
#(
    parameter int unsigned DATA_W       = 8,
    parameter int unsigned BUF_DEPTH    = 128,
    parameter int unsigned SLOT_BYTES   = 64,
    parameter int unsigned MAX_ATTEMPTS = 16,
    parameter int unsigned BACKOFF_CAP  = 10,
    parameter logic [15:0] LFSR_SEED    = 16'hACE1
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                frame_start,
    input  logic                                wr_en,
    input  logic [DATA_W-1:0]                   wr_data,
    input  logic                                rd_en,
    input  logic                                byte_tick,
    input  logic                                tx_end,
    input  logic                                collision,
    output logic [DATA_W-1:0]                   rd_data,
    output logic                                rd_empty,
    output logic                                wr_full,
    output logic                                restart,
    output logic                                buf_release,
    output logic                                frame_release,
    output logic                                done,
    output logic                                retry_err,
    output logic                                late_err,
    output logic [$clog2(MAX_ATTEMPTS+1)-1:0]   attempts,
    output logic [BACKOFF_CAP-1:0]              backoff_slots
);
    localparam int unsigned ATT_W = $clog2(MAX_ATTEMPTS + 1);
    localparam int unsigned WIN_W = $clog2(SLOT_BYTES + 1);
    localparam int unsigned BO_W  = BACKOFF_CAP + WIN_W;

    rc_state_e               st;
    logic [ATT_W-1:0]        att_q;
    logic [WIN_W-1:0]        win_q;
    logic                    rel_q;
    logic [BO_W-1:0]         bo_q;
    logic [BACKOFF_CAP-1:0]  slots_q;
    logic [BACKOFF_CAP-1:0]  draw_mask;
    logic [BACKOFF_CAP-1:0]  draw;
    rc_status_t              stat_q;
    logic                    restart_q;
    logic                    frel_q;
    logic [15:0]             lfsr_v;
    logic                    in_send;
    logic                    early_col;
    int unsigned             exp_n;

    assign in_send   = (st == ST_SEND);
    assign early_col = in_send && collision && !rel_q && !frame_start;

    rc_lfsr #(.SEED(LFSR_SEED)) lfsr_i (
        .clk   (clk),
        .rst   (rst),
        .value (lfsr_v)
    );

    rc_replay_buf #(.DATA_W(DATA_W), .DEPTH(BUF_DEPTH)) buf_i (
        .clk        (clk),
        .rst        (rst),
        .flush      (frame_start),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .rd_en      (rd_en && in_send),
        .rewind     (early_col),
        .release_en (rel_q),
        .rd_data    (rd_data),
        .empty      (rd_empty),
        .full       (wr_full)
    );

    // Backoff range: collisions so far (equal to att_q), capped.
    always_comb begin
        exp_n = rc_cap_exp(32'(att_q), BACKOFF_CAP);
        for (int i = 0; i < int'(BACKOFF_CAP); i++) begin
            draw_mask[i] = (32'(i) < exp_n);
        end
        draw = lfsr_v[BACKOFF_CAP-1:0] & draw_mask;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            att_q     <= '0;
            win_q     <= '0;
            rel_q     <= 1'b0;
            bo_q      <= '0;
            slots_q   <= '0;
            stat_q    <= '0;
            restart_q <= 1'b0;
            frel_q    <= 1'b0;
        end else if (frame_start) begin
            st        <= ST_SEND;
            att_q     <= ATT_W'(1);
            win_q     <= '0;
            rel_q     <= 1'b0;
            bo_q      <= '0;
            slots_q   <= '0;
            stat_q    <= '0;
            restart_q <= 1'b0;
            frel_q    <= 1'b0;
        end else begin
            restart_q <= 1'b0;
            frel_q    <= 1'b0;
            unique case (st)
                ST_SEND: begin
                    if (collision) begin
                        if (rel_q) begin
                            stat_q.late_err <= 1'b1;
                            frel_q          <= 1'b1;
                            st              <= ST_IDLE;
                        end else if (att_q == ATT_W'(MAX_ATTEMPTS)) begin
                            stat_q.retry_err <= 1'b1;
                            frel_q           <= 1'b1;
                            st               <= ST_IDLE;
                        end else begin
                            att_q   <= att_q + ATT_W'(1);
                            slots_q <= draw;
                            bo_q    <= BO_W'(draw) * BO_W'(SLOT_BYTES);
                            win_q   <= '0;
                            st      <= ST_WAIT;
                        end
                    end else if (tx_end) begin
                        stat_q.done <= 1'b1;
                        frel_q      <= 1'b1;
                        st          <= ST_IDLE;
                    end else if (byte_tick && !rel_q) begin
                        win_q <= win_q + WIN_W'(1);
                        if (win_q == WIN_W'(SLOT_BYTES - 1)) rel_q <= 1'b1;
                    end
                end
                ST_WAIT: begin
                    if (bo_q == '0) begin
                        restart_q <= 1'b1;
                        st        <= ST_SEND;
                    end else if (byte_tick) begin
                        bo_q <= bo_q - BO_W'(1);
                    end
                end
                default: ;
            endcase
        end
    end

    assign restart       = restart_q;
    assign buf_release   = rel_q;
    assign frame_release = frel_q;
    assign done          = stat_q.done;
    assign retry_err     = stat_q.retry_err;
    assign late_err      = stat_q.late_err;
    assign attempts      = att_q;
    assign backoff_slots = slots_q;
endmodule

// File: rtl/rc_retry_checker.sv
module rc_retry_checker #(
    parameter int unsigned MAX_ATTEMPTS = 16,
    parameter int unsigned BACKOFF_CAP  = 10
) (
    input logic                              clk,
    input logic                              rst,
    input logic [$clog2(MAX_ATTEMPTS+1)-1:0] attempts,
    input logic                              done,
    input logic                              retry_err,
    input logic                              late_err,
    input logic                              frame_release,
    input logic                              restart,
    input logic                              buf_release,
    input logic [BACKOFF_CAP-1:0]            backoff_slots
);
    int unsigned lim;

    always_comb begin
        if (attempts == '0)                             lim = 0;
        else if (32'(attempts) - 1 < BACKOFF_CAP)       lim = 32'(attempts) - 1;
        else                                            lim = BACKOFF_CAP;
    end

    AST_ATTEMPT_BOUND: assert property (@(posedge clk) disable iff (rst)
        32'(attempts) <= MAX_ATTEMPTS);                                   // R3
    AST_RETRY_AT_LIMIT: assert property (@(posedge clk) disable iff (rst)
        $rose(retry_err) |-> 32'(attempts) == MAX_ATTEMPTS);             // R4
    AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (rst)
        (attempts != '0) |-> ((32'(backoff_slots) >> lim) == 0));        // R5
    AST_LATE_AFTER_WINDOW: assert property (@(posedge clk) disable iff (rst)
        $rose(late_err) |-> $past(buf_release));                          // R6
    AST_DONE_CLEAN: assert property (@(posedge clk) disable iff (rst)
        done |-> (!retry_err && !late_err));                              // R7
    AST_RELEASE_PULSE: assert property (@(posedge clk) disable iff (rst)
        frame_release |=> !frame_release);                                // R7
    AST_RESTART_PROTECTED: assert property (@(posedge clk) disable iff (rst)
        restart |-> !buf_release);                                        // R2
endmodule

bind coll_retry_ctrl rc_retry_checker #(
    .MAX_ATTEMPTS (MAX_ATTEMPTS),
    .BACKOFF_CAP  (BACKOFF_CAP)
) chk_i (
    .clk           (clk),
    .rst           (rst),
    .attempts      (attempts),
    .done          (done),
    .retry_err     (retry_err),
    .late_err      (late_err),
    .frame_release (frame_release),
    .restart       (restart),
    .buf_release   (buf_release),
    .backoff_slots (backoff_slots)
);

// File: tb/coll_retry_ctrl_tb_top.sv
module coll_retry_ctrl_tb_top;
    localparam int DEPTH = 32;
    localparam int SLOT  = 16;
    localparam int MAXA  = 16;
    localparam int CAP   = 4;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       rst = 1'b1;
    logic       frame_start = 0, wr_en = 0, rd_en = 0, byte_tick = 0, tx_end = 0, collision = 0;
    logic [7:0] wr_data = 0;
    logic [7:0] rd_data;
    logic       rd_empty, wr_full, restart, buf_release, frame_release, done, retry_err, late_err;
    logic [4:0] attempts;
    logic [CAP-1:0] backoff_slots;

    coll_retry_ctrl #(
        .DATA_W(8), .BUF_DEPTH(DEPTH), .SLOT_BYTES(SLOT),
        .MAX_ATTEMPTS(MAXA), .BACKOFF_CAP(CAP), .LFSR_SEED(16'hACE1)
    ) dut_i (
        .clk(clk), .rst(rst), .frame_start(frame_start), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .byte_tick(byte_tick), .tx_end(tx_end), .collision(collision),
        .rd_data(rd_data), .rd_empty(rd_empty), .wr_full(wr_full), .restart(restart),
        .buf_release(buf_release), .frame_release(frame_release), .done(done),
        .retry_err(retry_err), .late_err(late_err), .attempts(attempts),
        .backoff_slots(backoff_slots)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit wd_exp   = 0;
    bit seen_restart = 0;

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int m_st, m_att, m_win, m_rel, m_bo, m_done, m_rerr, m_lerr, m_restart, m_frel, m_draw;
    logic [7:0] q[$];
    int rdi, basei, nrd, lim;
    bit m_full, m_empty;

    always @(posedge clk) begin
        if (rst || frame_start) begin
            m_st = rst ? 0 : 1; m_att = rst ? 0 : 1;
            m_win = 0; m_rel = 0; m_bo = 0; m_done = 0; m_rerr = 0; m_lerr = 0;
            m_restart = 0; m_frel = 0; m_draw = 0;
            q.delete(); rdi = 0; basei = 0;
        end else begin
            m_restart = 0; m_frel = 0;
            m_full  = (q.size() - basei) >= DEPTH;
            m_empty = rdi >= q.size();
            nrd = rdi;
            if (m_st == 1 && rd_en && !m_empty) nrd = rdi + 1;
            if (m_st == 1 && collision && m_rel == 0) nrd = basei;
            if (m_rel != 0) basei = nrd;
            rdi = nrd;
            if (wr_en && !m_full) q.push_back(wr_data);
            if (m_st == 1) begin
                if (collision) begin
                    if (m_rel != 0) begin m_lerr = 1; m_frel = 1; m_st = 0; end
                    else if (m_att == MAXA) begin m_rerr = 1; m_frel = 1; m_st = 0; end
                    else begin m_att++; m_draw = 1; m_win = 0; m_st = 2; end
                end else if (tx_end) begin
                    m_done = 1; m_frel = 1; m_st = 0;
                end else if (byte_tick && m_rel == 0) begin
                    m_win++;
                    if (m_win == SLOT) m_rel = 1;
                end
            end else if (m_st == 2) begin
                if (m_bo == 0) begin m_restart = 1; m_st = 1; end
                else if (byte_tick) m_bo--;
            end
        end
    end

    always @(negedge clk) begin
        if (restart) seen_restart = 1;
        if (!rst && !wd_exp) begin
            if (m_draw != 0) begin
                lim = (m_att - 1 < CAP) ? m_att - 1 : CAP;
                chk("R5", "backoff_slots within range", int'(backoff_slots) < (1 << lim), 1);
                m_bo = int'(backoff_slots) * SLOT;
                m_draw = 0;
            end
            chk("R3", "attempts", int'(attempts), m_att);
            chk("R4", "retry_err", int'(retry_err), m_rerr);
            chk("R6", "late_err", int'(late_err), m_lerr);
            chk("R7", "done", int'(done), m_done);
            chk("R7", "frame_release", int'(frame_release), m_frel);
            chk("R5", "restart", int'(restart), m_restart);
            chk("R2", "buf_release", int'(buf_release), m_rel);
            chk("R8", "wr_full", int'(wr_full), int'((q.size() - basei) >= DEPTH));
            chk("R10", "rd_empty", int'(rd_empty), int'(rdi >= q.size()));
            if (!rd_empty && rdi < q.size()) chk("R10", "rd_data", int'(rd_data), int'(q[rdi]));
        end
    end

    // ---------------- stimulus ----------------
    task automatic drive(input bit fs, input bit we, input logic [7:0] wd, input bit re,
                         input bit tk, input bit col, input bit te);
        @(negedge clk);
        frame_start = fs; wr_en = we; wr_data = wd; rd_en = re;
        byte_tick = tk; collision = col; tx_end = te;
    endtask

    task automatic idle();
        drive(0, 0, 8'h00, 0, 0, 0, 0);
    endtask

    task automatic start_frame();
        drive(1, 0, 8'h00, 0, 0, 0, 0);
        idle();
    endtask

    task automatic write_n(input int n, input int first);
        for (int i = 0; i < n; i++) drive(0, 1, 8'(first + i), 0, 0, 0, 0);
        idle();
    endtask

    task automatic send_n(input int n);
        for (int i = 0; i < n; i++) begin
            drive(0, 0, 8'h00, 1, 1, 0, 0);
            idle();
        end
    endtask

    task automatic collide();
        drive(0, 0, 8'h00, 0, 0, 1, 0);
        idle();
    endtask

    task automatic end_tx();
        drive(0, 0, 8'h00, 0, 0, 0, 1);
        idle();
    endtask

    task automatic wait_restart();
        seen_restart = 0;
        while (!seen_restart) begin
            drive(0, 0, 8'h00, 0, 1, 0, 0);
            idle();
        end
        idle();
    endtask

    task automatic run_all();
        logic [7:0] held;
        repeat (3) @(negedge clk);
        rst = 0;
        idle();
        // R1: reset state
        chk("R1", "attempts after reset", int'(attempts), 0);
        chk("R1", "rd_empty after reset", int'(rd_empty), 1);
        chk("R1", "buf_release after reset", int'(buf_release), 0);

        // Clean frame: release after SLOT ticks, then success (R2, R7, R10)
        start_frame();
        chk("R1", "attempts after frame_start", int'(attempts), 1);
        write_n(24, 8'h10);
        send_n(20);
        chk("R2", "released after window", int'(buf_release), 1);
        end_tx();
        chk("R7", "done after tx_end", int'(done), 1);

        // R9: stray controls while idle
        held = rd_data;
        drive(0, 0, 8'h00, 1, 1, 1, 1);
        idle(); idle();
        chk("R9", "late_err unchanged in idle", int'(late_err), 0);
        chk("R9", "attempts unchanged in idle", int'(attempts), 1);
        chk("R9", "rd_data unchanged in idle", int'(rd_data), int'(held));

        // One early collision, replay from first byte (R2, R5)
        start_frame();
        write_n(24, 8'h40);
        send_n(5);
        collide();
        wait_restart();
        chk("R2", "replay shows first byte", int'(rd_data), 8'h40);
        chk("R3", "second attempt", int'(attempts), 2);
        send_n(20);
        end_tx();

        // Every attempt collides (R3, R4)
        start_frame();
        write_n(10, 8'h80);
        for (int a = 1; a <= MAXA; a++) begin
            send_n(3);
            collide();
            if (a < MAXA) wait_restart();
        end
        idle();
        chk("R4", "retry_err after last attempt", int'(retry_err), 1);
        chk("R3", "attempts at limit", int'(attempts), MAXA);

        // Late collision (R6)
        start_frame();
        write_n(24, 8'hA0);
        send_n(17);
        collide();
        chk("R6", "late_err after window", int'(late_err), 1);
        chk("R6", "no retry after late collision", int'(attempts), 1);

        // Protected fill (R8)
        start_frame();
        write_n(40, 8'h00);
        chk("R8", "full while protected", int'(wr_full), 1);
        send_n(10);
        chk("R8", "still full before release", int'(wr_full), 1);
        send_n(8);
        chk("R8", "space freed after release", int'(wr_full), 0);
        end_tx();

        // New frame during a backoff (R1)
        start_frame();
        write_n(8, 8'hC0);
        send_n(4);
        collide();
        start_frame();
        chk("R1", "attempts cleared by new frame", int'(attempts), 1);
        chk("R1", "buffer emptied by new frame", int'(rd_empty), 1);
        write_n(4, 8'hD0);
        send_n(4);
        end_tx();
        repeat (4) idle();
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                wd_exp = 1;
                n_checks++;
                n_fail++;
                $display("FAIL watchdog: actual hung expected completion");
            end
        join_any
        disable fork;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule